// File: doc/BRIEF.md
# Frame Buffer Rectangle Transfer Sequencer

This block moves a rectangle of 16-bit pixels between a 32-bit host word port and a frame buffer that is 1024 pixels wide and 512 rows tall. A one-cycle start strobe carries a position word, a size word, a direction flag and a mask-set flag. The sequencer then walks the rectangle from left to right and from the top row down. It produces one pixel address per cycle whenever pixel data can move. Each host word packs two pixels, and the low half always goes first.

In write mode the host supplies words through a valid/ready handshake. The sequencer writes each pixel to the frame buffer and can force the top pixel bit to 1. In read mode the sequencer reads pixels through a combinational read port, packs them into words, and offers each word to the host through a valid/ready handshake. A flag tells the host that image data is on offer. The host may pause at any point. Because the walk position is held in registers, a row interrupted by a pause carries on from the same column, and a word that straddles the end of a row feeds the next row. Column and row addresses wrap around the frame buffer edges. A start that arrives while a transfer is still running discards the old transfer and flags the restart.

Top module: `vram_xfer_seq`

## Requirements
- R1: The start column is `pos_i[9:0]` and the start row is `pos_i[24:16]`. All other position bits are ignored.
- R2: The width is ((`size_i[9:0]` − 1) mod 1024) + 1 and the height is ((`size_i[24:16]` − 1) mod 512) + 1, so a zero field means 1024 columns or 512 rows. All other size bits are ignored.
- R3: Pixels move in row-major order, one per cycle at most. The pixel address is `{row[8:0], column[9:0]}`, and within a host word bits 15:0 are the first pixel and bits 31:16 the second.
- R4: The column is (start column + offset) mod 1024 and the row is (start row + row index) mod 512.
- R5: A pause in host traffic, including one in the middle of a row, loses no pixel position. A word that crosses a row end continues on the next row.
- R6: In write mode, when `mask_set_i` was 1 at start, bit 15 of every written pixel is 1.
- R7: In read mode, pixels are packed two per word with the low half first. When the pixel count is odd, the final word has zero in bits 31:16. A word is offered on `host_rvalid_o` until it is taken with `host_rready_i`.
- R8: `img_ready_o` goes to 1 in the cycle after a read start and returns to 0 in the cycle after the last pixel is read.
- R9: `done_o` is a one-cycle pulse in the cycle after the last pixel moves. `busy_o` is 0 once no pixel and no unread word remain.
- R10: A start while `busy_o` is 1 gives a one-cycle `restart_o` pulse in the next cycle. The old transfer's pending word and remaining pixels are dropped, no `done_o` is issued for the old transfer, and the new transfer runs. A start while idle leaves `restart_o` at 0.
- R11: During and just after reset, `busy_o`, `host_wready_o`, `host_rvalid_o`, `pix_we_o`, `done_o`, `img_ready_o` and `restart_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle start strobe |
| pos_i | input | 32 | Position word: column and row |
| size_i | input | 32 | Size word: width and height fields |
| read_i | input | 1 | 1 selects read mode, 0 selects write mode (sampled at start) |
| mask_set_i | input | 1 | Forces bit 15 of written pixels (sampled at start) |
| host_wvalid_i | input | 1 | Host word valid (write mode) |
| host_wdata_i | input | 32 | Host word with two pixels |
| host_wready_o | output | 1 | Sequencer accepts a host word |
| host_rvalid_o | output | 1 | A packed read word is on offer |
| host_rdata_o | output | 32 | Packed read word |
| host_rready_i | input | 1 | Host takes the read word |
| pix_addr_o | output | 19 | Pixel address {row, column} |
| pix_wdata_o | output | 16 | Pixel write data |
| pix_we_o | output | 1 | Pixel write enable |
| pix_rdata_i | input | 16 | Pixel read data, combinational from pix_addr_o |
| busy_o | output | 1 | Transfer in progress or read word pending |
| done_o | output | 1 | Pulse after the last pixel moves |
| img_ready_o | output | 1 | Read image data is available |
| restart_o | output | 1 | Pulse: a start replaced a running transfer |

## Verification
Two events can fall in the same cycle: a new start and the final pixel step of the running transfer. The bench provokes this by feeding a write transfer with an even pixel count and no gaps. In the cycle where the last pixel would be written, it raises a new start. The bench then checks that no pixel is written in that cycle, that no done pulse is counted for the old transfer, that the restart pulse appears one cycle later, and that the replacement transfer writes every expected pixel from its own first address.

// File: rtl/vxs_pkg.sv
`timescale 1ns/1ps
package vxs_pkg;
  typedef enum logic {
    XFER_WR = 1'b0,
    XFER_RD = 1'b1
  } xfer_dir_e;
endpackage

// File: rtl/vxs_decode.sv
`timescale 1ns/1ps
// Turns the position and size words into start coordinates and extents.
module vxs_decode #(
  parameter int X_BITS = 10,
  parameter int Y_BITS = 9,
  parameter int Y_LSB  = 16,
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] pos_i,
  input  logic [WORD_W-1:0] size_i,
  output logic [X_BITS-1:0] x0_o,
  output logic [Y_BITS-1:0] y0_o,
  output logic [X_BITS-1:0] wm1_o,
  output logic [Y_BITS:0]   rows_o
);
  logic [Y_BITS-1:0] hm1;

  assign x0_o   = pos_i[X_BITS-1:0];
  assign y0_o   = pos_i[Y_LSB +: Y_BITS];
  // field minus one, wrapping, so a zero field gives the full extent
  assign wm1_o  = size_i[X_BITS-1:0] - X_BITS'(1);
  assign hm1    = size_i[Y_LSB +: Y_BITS] - Y_BITS'(1);
  assign rows_o = {1'b0, hm1} + (Y_BITS+1)'(1);
endmodule

// File: rtl/vxs_addr_walk.sv
`timescale 1ns/1ps
// Holds the walk position inside the rectangle; wraps both axes.
module vxs_addr_walk #(
  parameter int X_BITS = 10,
  parameter int Y_BITS = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load_i,
  input  logic [X_BITS-1:0]        x0_i,
  input  logic [Y_BITS-1:0]        y0_i,
  input  logic [X_BITS-1:0]        wm1_i,
  input  logic [Y_BITS:0]          rows_i,
  input  logic                     step_i,
  output logic [X_BITS+Y_BITS-1:0] addr_o,
  output logic                     last_o
);
  logic [X_BITS-1:0] x0_q, col_q, wm1_q, col_n, x0_n, wm1_n;
  logic [Y_BITS-1:0] y_q, y_n;
  logic [Y_BITS:0]   rows_q, rows_n;
  logic [X_BITS-1:0] xcol;
  logic              row_end, en;

  assign row_end = (col_q == wm1_q);
  assign last_o  = row_end && (rows_q == (Y_BITS+1)'(1));
  assign xcol    = x0_q + col_q;
  assign addr_o  = {y_q, xcol};
  assign en      = load_i | step_i;

  always_comb begin
    x0_n   = x0_q;
    wm1_n  = wm1_q;
    col_n  = col_q;
    y_n    = y_q;
    rows_n = rows_q;
    if (load_i) begin
      x0_n   = x0_i;
      wm1_n  = wm1_i;
      col_n  = '0;
      y_n    = y0_i;
      rows_n = rows_i;
    end else if (step_i) begin
      if (row_end) begin
        col_n  = '0;
        y_n    = y_q + Y_BITS'(1);
        rows_n = rows_q - (Y_BITS+1)'(1);
      end else begin
        col_n  = col_q + X_BITS'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x0_q   <= '0;
      wm1_q  <= '0;
      col_q  <= '0;
      y_q    <= '0;
      rows_q <= '0;
    end else if (en) begin
      x0_q   <= x0_n;
      wm1_q  <= wm1_n;
      col_q  <= col_n;
      y_q    <= y_n;
      rows_q <= rows_n;
    end
  end
endmodule

// File: rtl/vxs_word_buf.sv
`timescale 1ns/1ps
// One host word split into pixel lanes: unpacked on writes, packed on reads.
module vxs_word_buf #(
  parameter int PIX_W  = 16,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic              load_i,
  input  logic [WORD_W-1:0] load_word_i,
  input  logic              fill_i,
  input  logic [PIX_W-1:0]  fill_pix_i,
  input  logic              drain_i,
  input  logic              take_i,
  input  logic              last_i,
  output logic              full_o,
  output logic [WORD_W-1:0] word_o,
  output logic [PIX_W-1:0]  lane_o
);
  localparam int LANES = WORD_W / PIX_W;
  localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1;

  logic [WORD_W-1:0] word_q, word_n;
  logic [IDX_W-1:0]  idx_q, idx_n;
  logic              full_q, full_n;
  logic              close, en;

  assign close  = (idx_q == IDX_W'(LANES-1)) | last_i;
  assign full_o = full_q;
  assign word_o = word_q;
  assign lane_o = word_q[idx_q*PIX_W +: PIX_W];
  assign en     = flush_i | load_i | fill_i | drain_i | take_i;

  always_comb begin
    word_n = word_q;
    full_n = full_q;
    idx_n  = idx_q;
    if (flush_i) begin
      full_n = 1'b0;
      idx_n  = '0;
    end else if (load_i) begin
      word_n = load_word_i;
      full_n = 1'b1;
      idx_n  = '0;
    end else if (fill_i) begin
      for (int l = 0; l < LANES; l++) begin
        if (IDX_W'(l) == idx_q)
          word_n[l*PIX_W +: PIX_W] = fill_pix_i;
        else if (idx_q == '0)
          word_n[l*PIX_W +: PIX_W] = '0;
      end
      if (close) begin
        full_n = 1'b1;
        idx_n  = '0;
      end else begin
        idx_n  = idx_q + IDX_W'(1);
      end
    end else if (drain_i) begin
      if (close) begin
        full_n = 1'b0;
        idx_n  = '0;
      end else begin
        idx_n  = idx_q + IDX_W'(1);
      end
    end else if (take_i) begin
      full_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      full_q <= 1'b0;
      idx_q  <= '0;
    end else if (en) begin
      word_q <= word_n;
      full_q <= full_n;
      idx_q  <= idx_n;
    end
  end
endmodule

// File: rtl/vram_xfer_seq.sv
`timescale 1ns/1ps
module vram_xfer_seq
  import vxs_pkg::*;
#(
  parameter int X_BITS = 10,
  parameter int Y_BITS = 9,
  parameter int Y_LSB  = 16,
  parameter int PIX_W  = 16,
  parameter int WORD_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic [WORD_W-1:0]        pos_i,
  input  logic [WORD_W-1:0]        size_i,
  input  logic                     read_i,
  input  logic                     mask_set_i,
  input  logic                     host_wvalid_i,
  input  logic [WORD_W-1:0]        host_wdata_i,
  output logic                     host_wready_o,
  output logic                     host_rvalid_o,
  output logic [WORD_W-1:0]        host_rdata_o,
  input  logic                     host_rready_i,
  output logic [X_BITS+Y_BITS-1:0] pix_addr_o,
  output logic [PIX_W-1:0]         pix_wdata_o,
  output logic                     pix_we_o,
  input  logic [PIX_W-1:0]         pix_rdata_i,
  output logic                     busy_o,
  output logic                     done_o,
  output logic                     img_ready_o,
  output logic                     restart_o
);
  localparam logic [PIX_W-1:0] MASK_BIT = PIX_W'(1) << (PIX_W-1);

  // reset: asserted at once, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  logic [X_BITS-1:0] dec_x0, dec_wm1;
  logic [Y_BITS-1:0] dec_y0;
  logic [Y_BITS:0]   dec_rows;

  vxs_decode #(
    .X_BITS(X_BITS), .Y_BITS(Y_BITS), .Y_LSB(Y_LSB), .WORD_W(WORD_W)
  ) u_decode (
    .pos_i (pos_i),
    .size_i(size_i),
    .x0_o  (dec_x0),
    .y0_o  (dec_y0),
    .wm1_o (dec_wm1),
    .rows_o(dec_rows)
  );

  xfer_dir_e dir_q, dir_n;
  logic active_q, active_n;
  logic mask_q, mask_n;
  logic img_q, img_n;
  logic done_q, done_n;
  logic restart_q, restart_n;
  logic step, last, buf_full, is_rd, state_en;
  logic [PIX_W-1:0] lane_pix;

  assign is_rd = (dir_q == XFER_RD);
  assign step  = active_q & ~start_i & (is_rd ? ~buf_full : buf_full);

  vxs_addr_walk #(.X_BITS(X_BITS), .Y_BITS(Y_BITS)) u_walk (
    .clk   (clk),
    .rst_n (rst_core_n),
    .load_i(start_i),
    .x0_i  (dec_x0),
    .y0_i  (dec_y0),
    .wm1_i (dec_wm1),
    .rows_i(dec_rows),
    .step_i(step),
    .addr_o(pix_addr_o),
    .last_o(last)
  );

  vxs_word_buf #(.PIX_W(PIX_W), .WORD_W(WORD_W)) u_buf (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .flush_i    (start_i),
    .load_i     (host_wvalid_i & host_wready_o),
    .load_word_i(host_wdata_i),
    .fill_i     (step & is_rd),
    .fill_pix_i (pix_rdata_i),
    .drain_i    (step & ~is_rd),
    .take_i     (host_rvalid_o & host_rready_i),
    .last_i     (last),
    .full_o     (buf_full),
    .word_o     (host_rdata_o),
    .lane_o     (lane_pix)
  );

  assign host_wready_o = active_q & ~is_rd & ~buf_full & ~start_i;
  assign host_rvalid_o = is_rd & buf_full;
  assign pix_we_o      = step & ~is_rd;
  assign pix_wdata_o   = mask_q ? (lane_pix | MASK_BIT) : lane_pix;
  assign busy_o        = active_q | buf_full;
  assign done_o        = done_q;
  assign img_ready_o   = img_q;
  assign restart_o     = restart_q;

  always_comb begin
    active_n  = active_q;
    dir_n     = dir_q;
    mask_n    = mask_q;
    img_n     = img_q;
    done_n    = step & last;
    restart_n = 1'b0;
    if (start_i) begin
      active_n  = 1'b1;
      dir_n     = read_i ? XFER_RD : XFER_WR;
      mask_n    = mask_set_i;
      img_n     = read_i;
      restart_n = busy_o;
    end else if (step && last) begin
      active_n  = 1'b0;
      img_n     = 1'b0;
    end
  end

  assign state_en = start_i | step | done_q | restart_q;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      active_q  <= 1'b0;
      dir_q     <= XFER_WR;
      mask_q    <= 1'b0;
      img_q     <= 1'b0;
      done_q    <= 1'b0;
      restart_q <= 1'b0;
    end else if (state_en) begin
      active_q  <= active_n;
      dir_q     <= dir_n;
      mask_q    <= mask_n;
      img_q     <= img_n;
      done_q    <= done_n;
      restart_q <= restart_n;
    end
  end
endmodule

// File: rtl/vxs_chk.sv
`timescale 1ns/1ps
module vxs_chk #(
  parameter int X_BITS = 10,
  parameter int Y_BITS = 9,
  parameter int PIX_W  = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     start_i,
  input logic                     read_i,
  input logic                     mask_set_i,
  input logic                     host_wready_o,
  input logic                     host_rvalid_o,
  input logic [X_BITS+Y_BITS-1:0] pix_addr_o,
  input logic [PIX_W-1:0]         pix_wdata_o,
  input logic                     pix_we_o,
  input logic                     busy_o,
  input logic                     done_o,
  input logic                     img_ready_o,
  input logic                     restart_o
);
  logic mask_arm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_arm_q <= 1'b0;
    else if (start_i) mask_arm_q <= mask_set_i & ~read_i;
  end

  // R7
  hs_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_wready_o && host_rvalid_o));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8
  img_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && read_i) |=> img_ready_o);

  // R8
  img_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !img_ready_o);

  // R10
  restart_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && busy_o) |=> restart_o);

  // R6
  mask_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_we_o && mask_arm_q && !start_i) |-> pix_wdata_o[PIX_W-1]);

  // R3
  write_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_we_o |-> busy_o);
endmodule

bind vram_xfer_seq vxs_chk #(
  .X_BITS(X_BITS), .Y_BITS(Y_BITS), .PIX_W(PIX_W)
) u_vxs_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .read_i       (read_i),
  .mask_set_i   (mask_set_i),
  .host_wready_o(host_wready_o),
  .host_rvalid_o(host_rvalid_o),
  .pix_addr_o   (pix_addr_o),
  .pix_wdata_o  (pix_wdata_o),
  .pix_we_o     (pix_we_o),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .img_ready_o  (img_ready_o),
  .restart_o    (restart_o)
);

// File: tb/test_vram_xfer_seq.sv
`timescale 1ns/1ps
module test_vram_xfer_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i, read_i, mask_set_i;
  logic [31:0] pos_i, size_i;
  logic        host_wvalid_i, host_wready_o, host_rvalid_o, host_rready_i;
  logic [31:0] host_wdata_i, host_rdata_o;
  logic [18:0] pix_addr_o;
  logic [15:0] pix_wdata_o, pix_rdata_i;
  logic        pix_we_o, busy_o, done_o, img_ready_o, restart_o;

  always #2.5 clk = ~clk;

  vram_xfer_seq i_vram_xfer_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .pos_i(pos_i), .size_i(size_i),
    .read_i(read_i), .mask_set_i(mask_set_i), .host_wvalid_i(host_wvalid_i),
    .host_wdata_i(host_wdata_i), .host_wready_o(host_wready_o),
    .host_rvalid_o(host_rvalid_o), .host_rdata_o(host_rdata_o),
    .host_rready_i(host_rready_i), .pix_addr_o(pix_addr_o),
    .pix_wdata_o(pix_wdata_o), .pix_we_o(pix_we_o), .pix_rdata_i(pix_rdata_i),
    .busy_o(busy_o), .done_o(done_o), .img_ready_o(img_ready_o),
    .restart_o(restart_o)
  );

  int    vectors = 0, fails = 0, cyc = 0;
  int    g_x0, g_y0, g_w, g_h, g_total, g_salt = 0;
  bit    g_mask;
  int    seen, rseen, dones, widx;
  string cur_req = "R11";

  function automatic logic [15:0] rd_model(logic [18:0] a);
    return 16'(a * 19'd13) ^ {13'd0, a[18:16]};
  endfunction
  assign pix_rdata_i = rd_model(pix_addr_o);

  function automatic logic [31:0] word_of(int salt, int k);
    logic [31:0] v = 32'(k) * 32'h9E3779B1 + 32'(salt) * 32'h01000193;
    return v ^ (v >> 13);
  endfunction

  function automatic logic [18:0] exp_addr(int k);
    int row = k / g_w;
    int col = k % g_w;
    return 19'(((g_y0 + row) % 512) * 1024 + (g_x0 + col) % 1024);
  endfunction

  function automatic logic [15:0] exp_wpix(int k);
    logic [31:0] wd = word_of(g_salt, k / 2);
    logic [15:0] p = (k % 2) ? wd[31:16] : wd[15:0];
    if (g_mask) p[15] = 1'b1;
    return p;
  endfunction

  function automatic logic [31:0] exp_rword(int j);
    logic [15:0] lo = rd_model(exp_addr(2*j));
    logic [15:0] hi = (2*j + 1 < g_total) ? rd_model(exp_addr(2*j + 1)) : 16'h0;
    return {hi, lo};
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 180000) begin
      fails++;
      $display("FAIL R9 watchdog actual=busy expected=idle");
      summary();
      $finish;
    end
  end

  // monitor, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (pix_we_o) begin
        chk(pix_addr_o == exp_addr(seen) && pix_wdata_o == exp_wpix(seen), cur_req,
            "pixel write {addr,data}", longint'({pix_addr_o, pix_wdata_o}),
            longint'({exp_addr(seen), exp_wpix(seen)}));
        seen++;
      end
      if (host_rvalid_o && host_rready_i) begin
        chk(host_rdata_o == exp_rword(rseen), cur_req, "read word",
            longint'(host_rdata_o), longint'(exp_rword(rseen)));
        rseen++;
      end
      if (done_o) dones++;
    end
  end

  task automatic begin_xfer(int x0, int y0, int wf, int hf, bit rd, bit mask,
                            bit exp_restart, string req);
    logic [31:0] junk = $urandom;
    cur_req = req;
    g_x0 = x0; g_y0 = y0;
    g_w  = (wf == 0) ? 1024 : wf;
    g_h  = (hf == 0) ? 512 : hf;
    g_total = g_w * g_h;
    g_mask = mask & ~rd;
    g_salt++;
    seen = 0; rseen = 0; dones = 0; widx = 0;
    pos_i  = {junk[31:25], 9'(y0), junk[15:10], 10'(x0)};
    size_i = {junk[24:18], 9'(hf), junk[9:4], 10'(wf)};
    read_i = rd; mask_set_i = mask;
    host_wdata_i = word_of(g_salt, 0);
    host_wvalid_i = ~rd;
    host_rready_i = rd;
    start_i = 1'b1;
    @(posedge clk); #1;
    start_i = 1'b0;
    chk(restart_o == exp_restart, "R10", "restart flag", restart_o, exp_restart);
    if (rd) chk(img_ready_o == 1'b1, "R8", "image ready after read start", img_ready_o, 1);
  endtask

  // returns when idle, or early once abort_at pixels have been written
  task automatic run_xfer(int gap, int abort_at);
    bit acc;
    forever begin
      @(negedge clk);
      acc = host_wvalid_i && host_wready_o;
      if (!busy_o) break;
      @(posedge clk); #1;
      if (acc) widx++;
      host_wdata_i  = word_of(g_salt, widx);
      host_wvalid_i = ~read_i && (($urandom % 100) >= gap);
      host_rready_i = read_i && (($urandom % 100) >= gap);
      if (abort_at >= 0 && seen == abort_at) return;
    end
    @(posedge clk); #1;
    host_wvalid_i = 1'b0;
    host_rready_i = 1'b0;
  endtask

  task automatic finish_xfer(string req);
    bit rd = read_i;
    chk(seen == (rd ? 0 : g_total), req, "pixels written", seen, rd ? 0 : g_total);
    chk(rseen == (rd ? (g_total + 1) / 2 : 0), req, "words read", rseen,
        rd ? (g_total + 1) / 2 : 0);
    chk(dones == 1, "R9", "done pulses", dones, 1);
    chk(busy_o == 1'b0, "R9", "busy after end", busy_o, 0);
    chk(img_ready_o == 1'b0, "R8", "image ready after end", img_ready_o, 0);
  endtask

  task automatic xfer(int x0, int y0, int wf, int hf, bit rd, bit mask, int gap, string req);
    begin_xfer(x0, y0, wf, hf, rd, mask, 1'b0, req);
    run_xfer(gap, -1);
    finish_xfer(req);
  endtask

  initial begin
    void'($urandom(32'h1CE5EED));
    rst_n = 1'b0; start_i = 1'b0; read_i = 1'b0; mask_set_i = 1'b0;
    pos_i = '0; size_i = '0; host_wvalid_i = 1'b0; host_wdata_i = '0;
    host_rready_i = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R11
    chk({busy_o, host_wready_o, host_rvalid_o, pix_we_o, done_o, img_ready_o, restart_o} == 7'b0,
        "R11", "idle outputs after reset",
        longint'({busy_o, host_wready_o, host_rvalid_o, pix_we_o, done_o, img_ready_o, restart_o}), 0);

    // directed corners
    xfer(1020, 510, 8, 4, 1'b0, 1'b1, 0,  "R4 R6");   // both axes wrap, mask forced
    xfer(3, 7, 0, 1, 1'b0, 1'b0, 0,       "R2");      // zero width field -> 1024
    xfer(900, 300, 1, 0, 1'b1, 1'b0, 20,  "R2 R4");   // zero height field -> 512, read
    xfer(50, 60, 5, 3, 1'b1, 1'b0, 50,    "R5 R7");   // odd width read with pauses
    xfer(70, 80, 3, 3, 1'b0, 1'b0, 60,    "R5");      // odd width write with pauses
    xfer(0, 0, 1, 1, 1'b1, 1'b0, 0,       "R7");      // single pixel read, zero upper half

    // restart on the cycle of the last pixel write
    begin_xfer(100, 20, 8, 2, 1'b0, 1'b0, 1'b0, "R10");
    run_xfer(0, 15);
    chk(dones == 0, "R10", "no done before replacement", dones, 0);
    begin_xfer(200, 40, 6, 2, 1'b0, 1'b1, 1'b1, "R10");
    run_xfer(10, -1);
    finish_xfer("R10");

    // constrained random
    for (int t = 0; t < 16; t++) begin
      xfer($urandom % 1024, $urandom % 512, 1 + $urandom % 40, 1 + $urandom % 6,
           1'($urandom), 1'($urandom), $urandom % 60, "R1 R3 R7");
    end

    summary();
    $finish;
  end
endmodule